// File: doc/BRIEF.md
# One-Time-Programmable Wiper Controller

This block is the digital control core of a 64-position potentiometer whose setting can be frozen once and for all. A serial slave front end, outside this block, decodes bus traffic into write frames (address, instruction byte, data byte) and read strobes. The block keeps the 6-bit wiper code, accepts any number of updates while the part is blank, and on request runs a single commit sequence. That sequence drives modelled fuse-blow requests in turn and then judges modelled verify results.

The outcome is kept as a 2-bit status that a read frame returns next to the wiper code. After a commit attempt the wiper is frozen. On every later power-on (synchronous reset) the block reloads the wiper from the stored fuse value instead of starting at midscale.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: On reset with the lock fuse input clear, the wiper becomes midscale (code 32) and the status reads 00 (ready).
- R2: On reset with the lock fuse input set, the wiper loads fuse_data_in, the status reads 11, and later write frames change nothing.
- R3: A frame is accepted only when its 7-bit address equals 0101100 with the least significant bit replaced by addr_pin. Frames with any other address, for writing or reading, have no effect and produce no read response.
- R4: While the part is uncommitted, every accepted write frame loads wr_data[5:0] into the wiper, any number of times, and wr_data[7:6] are ignored.
- R5: An accepted write frame with instruction bit 6 (the program bit) set loads its data into the wiper and starts the commit sequence with that value.
- R6: The commit sequence asserts blow_data_req, then blow_test_req, then blow_lock_req, each for exactly BLOW_CYCLES cycles and never two at once, with fuse_wr_data equal to the wiper code.
- R7: After the lock step the status becomes 11 if verify_data_ok and verify_test_ok are both high, 01 if only verify_test_ok is low, and 10 whenever verify_data_ok is low.
- R8: Only one commit attempt is allowed. Once it has started, write frames and program bits are ignored and the status stays latched until the next reset, whether the attempt passed or failed.
- R9: An accepted read strobe gives, one cycle later, a one-cycle rd_valid pulse with rd_byte = {E1, E0, D5..D0}: status in bits 7:6, wiper in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| addr_pin | input | 1 | Strap that sets the address LSB |
| wr_valid | input | 1 | Decoded write frame present this cycle |
| wr_addr | input | 7 | Write frame slave address |
| wr_instr | input | 8 | Write frame instruction byte, bit 6 = program |
| wr_data | input | 8 | Write frame data byte, bits 5:0 = wiper code |
| rd_start | input | 1 | Start-of-read strobe |
| rd_addr | input | 7 | Read frame slave address |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_byte | output | 8 | Status and wiper code |
| wiper | output | 6 | Current wiper code to the resistor array |
| blow_data_req | output | 1 | Data fuse blow request |
| blow_test_req | output | 1 | Test fuse blow request |
| blow_lock_req | output | 1 | Lock fuse blow request |
| fuse_wr_data | output | 6 | Value to store in the data fuses |
| verify_data_ok | input | 1 | Modelled data fuse verify result |
| verify_test_ok | input | 1 | Modelled test fuse verify result |
| fuse_lock_in | input | 1 | Stored lock fuse state |
| fuse_data_in | input | 6 | Stored data fuse value |

## Verification
The embedded assertions watch, on every cycle, that at most one blow request is active, that the test and lock steps only follow the previous step, that the sequence cannot leave its final state, and that the wiper and a non-ready status never move once committed. Only the bench scenarios can show the arithmetic content: the full sweep of 64 codes through the read path, the full address sweep under both strap values, the exact duration of each blow step, the four verify outcome encodings, and the reload of the stored value after a power-on.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_BLOW_DATA, S_BLOW_TEST, S_BLOW_LOCK, S_VERIFY, S_DONE
  } seq_state_t;

  localparam logic [1:0] ST_READY    = 2'b00;
  localparam logic [1:0] ST_TEST_BAD = 2'b01;
  localparam logic [1:0] ST_FATAL    = 2'b10;
  localparam logic [1:0] ST_GOOD     = 2'b11;

  localparam int PROG_BIT = 6;
endpackage

// File: rtl/otp_frame_decode.sv
module otp_frame_decode #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b0101100
) (
  input  logic              addr_pin,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_instr,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_hit,
  output logic              prog_hit,
  output logic              rd_hit
);
  logic [ADDR_W-1:0] own_addr;

  always_comb begin
    own_addr = {ADDR_BASE[ADDR_W-1:1], addr_pin};
    wr_hit   = wr_valid && (wr_addr == own_addr);
    prog_hit = wr_hit && wr_instr[otp_wiper_pkg::PROG_BIT];
    rd_hit   = rd_start && (rd_addr == own_addr);
  end
endmodule

// File: rtl/otp_wiper_reg.sv
module otp_wiper_reg #(
  parameter int WIPER_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fuse_lock_in,
  input  logic [WIPER_W-1:0] fuse_data_in,
  input  logic               wr_en,
  input  logic               locked,
  input  logic [WIPER_W-1:0] wr_code,
  output logic [WIPER_W-1:0] wiper
);
  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper <= fuse_lock_in ? fuse_data_in : MIDSCALE;
    end else if (wr_en && !locked) begin
      wiper <= wr_code;
    end
  end

  // R8: a committed wiper never moves until the next power-on
  p_wiper_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(wiper));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_wiper_pkg::*;
#(
  parameter int BLOW_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fuse_lock_in,
  input  logic       start,
  input  logic       verify_data_ok,
  input  logic       verify_test_ok,
  output logic       locked,
  output logic       blow_data_req,
  output logic       blow_test_req,
  output logic       blow_lock_req,
  output logic [1:0] status
);
  localparam int CNT_W = $clog2(BLOW_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOW_CYCLES - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             step_end;

  assign step_end = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= fuse_lock_in ? S_DONE : S_IDLE;
      status <= fuse_lock_in ? ST_GOOD : ST_READY;
      cnt    <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (start) state <= S_BLOW_DATA;
        end
        S_BLOW_DATA, S_BLOW_TEST, S_BLOW_LOCK: begin
          if (step_end) begin
            cnt <= '0;
            if (state == S_BLOW_DATA)      state <= S_BLOW_TEST;
            else if (state == S_BLOW_TEST) state <= S_BLOW_LOCK;
            else                           state <= S_VERIFY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_VERIFY: begin
          if (!verify_data_ok)      status <= ST_FATAL;
          else if (!verify_test_ok) status <= ST_TEST_BAD;
          else                      status <= ST_GOOD;
          state <= S_DONE;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    locked        = (state != S_IDLE);
    blow_data_req = (state == S_BLOW_DATA);
    blow_test_req = (state == S_BLOW_TEST);
    blow_lock_req = (state == S_BLOW_LOCK);
  end

  // R6: never two fuse groups at once, and strict step order
  p_one_blow_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({blow_data_req, blow_test_req, blow_lock_req}));
  p_test_after_data_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(blow_test_req) |-> $past(blow_data_req));
  p_lock_after_test_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(blow_lock_req) |-> $past(blow_test_req));
  // R8: single attempt, latched outcome
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_DONE) |=> (state == S_DONE));
  p_status_latched_r8: assert property (@(posedge clk) disable iff (rst)
    (status != ST_READY) |=> $stable(status));
endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl #(
  parameter int WIPER_W     = 6,
  parameter int ADDR_W      = 7,
  parameter int BLOW_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addr_pin,
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_instr,
  input  logic [7:0]         wr_data,
  input  logic               rd_start,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_valid,
  output logic [WIPER_W+1:0] rd_byte,
  output logic [WIPER_W-1:0] wiper,
  output logic               blow_data_req,
  output logic               blow_test_req,
  output logic               blow_lock_req,
  output logic [WIPER_W-1:0] fuse_wr_data,
  input  logic               verify_data_ok,
  input  logic               verify_test_ok,
  input  logic               fuse_lock_in,
  input  logic [WIPER_W-1:0] fuse_data_in
);
  logic       wr_hit, prog_hit, rd_hit, locked;
  logic [1:0] status;

  otp_frame_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_pin(addr_pin), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_instr(wr_instr), .rd_start(rd_start), .rd_addr(rd_addr),
    .wr_hit(wr_hit), .prog_hit(prog_hit), .rd_hit(rd_hit)
  );

  otp_wiper_reg #(.WIPER_W(WIPER_W)) u_wiper (
    .clk(clk), .rst(rst), .fuse_lock_in(fuse_lock_in),
    .fuse_data_in(fuse_data_in), .wr_en(wr_hit), .locked(locked),
    .wr_code(wr_data[WIPER_W-1:0]), .wiper(wiper)
  );

  otp_prog_seq #(.BLOW_CYCLES(BLOW_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .fuse_lock_in(fuse_lock_in), .start(prog_hit),
    .verify_data_ok(verify_data_ok), .verify_test_ok(verify_test_ok),
    .locked(locked), .blow_data_req(blow_data_req),
    .blow_test_req(blow_test_req), .blow_lock_req(blow_lock_req),
    .status(status)
  );

  assign fuse_wr_data = wiper;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      rd_valid <= rd_hit;
      if (rd_hit) rd_byte <= {status, wiper};
    end
  end

  // R9: a response only follows a matching read strobe
  p_rd_follows_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_hit));
  // R6: the fuse value offered during a blow step is held
  p_fuse_value_held_r6: assert property (@(posedge clk) disable iff (rst)
    (blow_data_req && $past(blow_data_req)) |-> $stable(fuse_wr_data));
endmodule

// File: tb/otp_wiper_ctrl_bench.sv
module otp_wiper_ctrl_bench;
  localparam int W  = 6;
  localparam int AW = 7;
  localparam int BC = 3;
  localparam logic [AW-1:0] BASE = 7'b0101100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_pin = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_instr = '0, wr_data = '0;
  logic rd_start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_valid;
  logic [W+1:0] rd_byte;
  logic [W-1:0] wiper, fuse_wr_data;
  logic blow_data_req, blow_test_req, blow_lock_req;
  logic verify_data_ok = 1'b1, verify_test_ok = 1'b1;

  logic fm_clear = 1'b0;
  logic fm_lock = 1'b0;
  logic [W-1:0] fm_data = '0;

  int vectors = 0;
  int fails = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (fm_clear) begin
      fm_lock <= 1'b0;
      fm_data <= '0;
    end else begin
      if (blow_data_req) fm_data <= fuse_wr_data;
      if (blow_lock_req) fm_lock <= 1'b1;
    end
  end

  otp_wiper_ctrl #(.WIPER_W(W), .ADDR_W(AW), .BLOW_CYCLES(BC)) u_otp_wiper_ctrl (
    .clk(clk), .rst(rst), .addr_pin(addr_pin), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_instr(wr_instr), .wr_data(wr_data),
    .rd_start(rd_start), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .wiper(wiper), .blow_data_req(blow_data_req),
    .blow_test_req(blow_test_req), .blow_lock_req(blow_lock_req),
    .fuse_wr_data(fuse_wr_data), .verify_data_ok(verify_data_ok),
    .verify_test_ok(verify_test_ok), .fuse_lock_in(fm_lock),
    .fuse_data_in(fm_data)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_on();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic blank_fuses();
    @(negedge clk) fm_clear = 1'b1;
    @(negedge clk) fm_clear = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] ins,
                          input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_instr = ins; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic v,
                         output logic [7:0] b);
    @(negedge clk);
    rd_start = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_start = 1'b0;
    v = rd_valid; b = rd_byte;
  endtask

  task automatic run_commit(input logic dok, input logic tok,
                            input logic [1:0] exp_st, input logic [W-1:0] code);
    int nd, nt, nl, fd, ft, fl, ov;
    logic v;
    logic [7:0] b;
    nd = 0; nt = 0; nl = 0; fd = -1; ft = -1; fl = -1; ov = 0;
    blank_fuses();
    power_on();
    verify_data_ok = dok; verify_test_ok = tok;
    do_write(BASE, 8'h40, {2'b00, code});
    check("R5 wiper takes program frame data", int'(wiper), int'(code));
    for (int i = 0; i < 3*BC + 6; i++) begin
      if (blow_data_req) begin nd++; if (fd < 0) fd = i; end
      if (blow_test_req) begin nt++; if (ft < 0) ft = i; end
      if (blow_lock_req) begin nl++; if (fl < 0) fl = i; end
      if (int'(blow_data_req) + int'(blow_test_req) + int'(blow_lock_req) > 1) ov++;
      @(negedge clk);
    end
    check("R6 data blow length", nd, BC);
    check("R6 test blow length", nt, BC);
    check("R6 lock blow length", nl, BC);
    check("R6 step order", int'(fd == 0 && ft == BC && fl == 2*BC), 1);
    check("R6 no overlap", ov, 0);
    check("R6 stored fuse value", int'(fm_data), int'(code));
    do_read(BASE, v, b);
    check("R7 status after commit", int'(b[7:6]), int'(exp_st));
    check("R9 read wiper field", int'(b[5:0]), int'(code));
    // R8: further writes and program bits are ignored
    do_write(BASE, 8'h00, {2'b00, ~code});
    do_write(BASE, 8'h40, {2'b00, ~code});
    nd = 0;
    for (int i = 0; i < 2*BC; i++) begin
      if (blow_data_req || blow_test_req || blow_lock_req) nd++;
      @(negedge clk);
    end
    check("R8 no second attempt", nd, 0);
    verify_data_ok = ~dok; verify_test_ok = ~tok;
    do_read(BASE, v, b);
    check("R8 wiper frozen", int'(b[5:0]), int'(code));
    check("R8 status latched", int'(b[7:6]), int'(exp_st));
    verify_data_ok = 1'b1; verify_test_ok = 1'b1;
    // R2: reload from fuses on the next power-on
    power_on();
    check("R2 reload wiper", int'(wiper), int'(code));
    do_read(BASE, v, b);
    check("R2 status after reload", int'(b[7:6]), 3);
    do_write(BASE, 8'h00, {2'b00, code ^ 6'h15});
    check("R2 writes ignored after reload", int'(wiper), int'(code));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic v;
    logic [7:0] b;
    power_on();
    // R1
    check("R1 midscale after reset", int'(wiper), 32);
    do_read(BASE, v, b);
    check("R9 read valid", int'(v), 1);
    check("R1 ready status", int'(b), 32);
    @(negedge clk);
    check("R9 valid is one pulse", int'(rd_valid), 0);

    // R4 + R9: exhaustive code sweep, upper data bits set
    for (int c = 0; c < 64; c++) begin
      do_write(BASE, 8'h00, {2'(c), 6'(c)});
      check("R4 wiper write", int'(wiper), c);
      do_read(BASE, v, b);
      check("R9 read byte", int'(b), c);
    end

    // R3: address sweep with both strap values
    for (int p = 0; p < 2; p++) begin
      addr_pin = 1'(p);
      do_write(BASE | 7'(p), 8'h00, 8'd5);
      for (int a = 0; a < 128; a++) begin
        if (a != (int'(BASE) | p)) begin
          do_write(7'(a), 8'h40, 8'(a));
          do_read(7'(a), v, b);
          check("R3 foreign read silent", int'(v), 0);
        end
      end
      do_read(BASE | 7'(p), v, b);
      check("R3 foreign frames ignored", int'(b), 5);
      check("R3 foreign program ignored", int'(fm_lock), 0);
    end
    addr_pin = 1'b0;

    // R5..R8, R2: four verify outcomes
    run_commit(1'b1, 1'b1, 2'b11, 6'h2A);
    run_commit(1'b1, 1'b0, 2'b01, 6'h07);
    run_commit(1'b0, 1'b1, 2'b10, 6'h3F);
    run_commit(1'b0, 1'b0, 2'b10, 6'h00);

    // R1 again: blank fuses restore midscale
    blank_fuses();
    power_on();
    check("R1 midscale after blank power-on", int'(wiper), 32);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule